// File: doc/BRIEF.md
# Branch History-Length Skip Table

This block keeps a short list of indirect branches that keep defeating a longest-match target predictor, and for each of them it says how far to back off from the longest matching history. It is a set-associative table looked up by branch PC. A lookup returns whether the branch is resident, its skip value and its miss counter. It also combines the skip value with the vector of tagged tables that matched, and picks the one table that supplies the final target.

Training is driven from retire. The retire stage presents the branch PC and a flag telling whether the longest-match prediction, and not the prediction actually used, was wrong. A resident branch that was mispredicted raises both its miss counter and its skip value. A resident branch that was predicted correctly has its miss counter lowered. A non-resident branch that was mispredicted takes the way holding the fewest misses, so over time the table holds the branches that miss most often. The lookup side is driven with the fetch-time history state and the update side with the retire-time state. The two ports are independent.

Top module: `hist_skip_table`

## Requirements
- R1: After reset no branch is resident. Every lookup reports hit 0, skip 0 and count 0.
- R2: On a lookup miss the skip value is 0 and the selector picks the highest-numbered matching table. Bit 0 of the match vector is the shortest history and bit 11 the longest.
- R3: With an all-zero match vector the selection-valid output is 0 and the selected index is 0. With any match it is 1.
- R4: On a hit with skip x, the selector passes over the x highest-numbered matching tables and picks the next one. With matches at bits 1, 3 and 4 and x=2, it picks bit 1.
- R5: When x is at least the number of matching tables, the selector picks the lowest-numbered matching table.
- R6: An update with the miss flag set for a non-resident PC allocates an entry with count 1 and skip 1.
- R7: An update with the miss flag set for a resident PC adds 1 to the 3-bit count and to the 4-bit skip. The count saturates at 7 and the skip saturates at 15.
- R8: An update with the miss flag clear for a resident PC lowers the count by 1, saturating at 0. The skip is left unchanged.
- R9: An update with the miss flag clear for a non-resident PC allocates nothing.
- R10: The allocation victim is chosen in this order: an invalid way first, otherwise the valid way with the smallest count. Ties go to the lowest way number.
- R11: The set index is PC bits [4:2] and the tag is PC bits [31:5]. PCs with the same tag in different sets are separate branches. Up to 4 different tags can be resident in one set at once.
- R12: A lookup is combinational on the stored state. An update becomes visible to lookups only after the clock edge on which it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_pc_i | input | 32 | Lookup branch PC |
| lk_match_i | input | 12 | Tag-match vector of the history tables, bit 0 shortest |
| lk_hit_o | output | 1 | Lookup PC is resident |
| lk_skip_o | output | 4 | Skip value of the resident entry, 0 on miss |
| lk_cnt_o | output | 3 | Miss counter of the resident entry, 0 on miss |
| lk_sel_valid_o | output | 1 | At least one table matched |
| lk_sel_o | output | 4 | Index of the table chosen to predict |
| upd_valid_i | input | 1 | Update request |
| upd_pc_i | input | 32 | Update branch PC |
| upd_miss_i | input | 1 | Longest-match prediction was wrong |

## Verification
The assertions rely on the lookup inputs being stable whenever no update is accepted. They also rely on skip values reaching storage only through allocation, which writes 1, and through increments. Because of that, any resident entry has a nonzero skip. The bench changes lookup inputs only between updates and keeps the update port idle while it sweeps. It reaches each skip value through real miss updates, so the stored state always stays inside the states the update rules can produce. The sweeps cover every 12-bit match vector at skip values 0 to 4 and at saturation.

// File: rtl/hst_pkg.sv
package hst_pkg;
  localparam int unsigned PC_W    = 32;
  localparam int unsigned SET_N   = 8;
  localparam int unsigned WAY_N   = 4;
  localparam int unsigned MC_W    = 3;
  localparam int unsigned SKIP_W  = 4;
  localparam int unsigned TBL_N   = 12;
  localparam int unsigned IDX_LSB = 2;

  localparam int unsigned SET_W = $clog2(SET_N);
  localparam int unsigned WAY_W = $clog2(WAY_N);
  localparam int unsigned TBL_W = $clog2(TBL_N);
  localparam int unsigned TAG_W = PC_W - IDX_LSB - SET_W;

  typedef struct packed {
    logic              vld;
    logic [TAG_W-1:0]  tag;
    logic [MC_W-1:0]   mc;
    logic [SKIP_W-1:0] skip;
  } hst_entry_t;
endpackage

// File: rtl/hst_way_search.sv
module hst_way_search
  import hst_pkg::*;
(
  input  hst_entry_t [WAY_N-1:0] row_i,
  input  logic [TAG_W-1:0]       tag_i,
  output logic                   hit_o,
  output logic [WAY_W-1:0]       hit_way_o,
  output logic [WAY_W-1:0]       vict_way_o
);
  logic [MC_W:0] best_key;

  always_comb begin
    hit_o     = 1'b0;
    hit_way_o = '0;
    for (int w = 0; w < int'(WAY_N); w++) begin
      if (!hit_o && row_i[w].vld && row_i[w].tag == tag_i) begin
        hit_o     = 1'b1;
        hit_way_o = WAY_W'(w);
      end
    end
  end

  // invalid ways sort below any valid way; strict compare keeps lowest way on ties
  always_comb begin
    best_key   = {row_i[0].vld, row_i[0].mc};
    vict_way_o = '0;
    for (int w = 1; w < int'(WAY_N); w++) begin
      if ({row_i[w].vld, row_i[w].mc} < best_key) begin
        best_key   = {row_i[w].vld, row_i[w].mc};
        vict_way_o = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/hst_select.sv
module hst_select
  import hst_pkg::*;
(
  input  logic [TBL_N-1:0]  match_i,
  input  logic [SKIP_W-1:0] skip_i,
  output logic              sel_valid_o,
  output logic [TBL_W-1:0]  sel_o
);
  logic             found;
  logic [TBL_W-1:0] pick;
  logic [TBL_W-1:0] lowest;
  int unsigned      seen;

  always_comb begin
    found  = 1'b0;
    pick   = '0;
    lowest = '0;
    seen   = 0;
    for (int i = int'(TBL_N) - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        if (!found && seen == int'(skip_i)) begin
          found = 1'b1;
          pick  = TBL_W'(i);
        end
        seen   = seen + 1;
        lowest = TBL_W'(i);
      end
    end
  end

  assign sel_valid_o = |match_i;
  assign sel_o       = found ? pick : lowest;
endmodule

// File: rtl/hist_skip_table.sv
module hist_skip_table
  import hst_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PC_W-1:0]   lk_pc_i,
  input  logic [TBL_N-1:0]  lk_match_i,
  output logic              lk_hit_o,
  output logic [SKIP_W-1:0] lk_skip_o,
  output logic [MC_W-1:0]   lk_cnt_o,
  output logic              lk_sel_valid_o,
  output logic [TBL_W-1:0]  lk_sel_o,
  input  logic              upd_valid_i,
  input  logic [PC_W-1:0]   upd_pc_i,
  input  logic              upd_miss_i
);
  hst_entry_t [WAY_N-1:0] rows [SET_N];

  logic [SET_W-1:0] lk_set, up_set;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic             lk_hit, up_hit;
  logic [WAY_W-1:0] lk_way, up_way, up_vict, lk_vict_unused;
  hst_entry_t       lk_ent;

  assign lk_set = lk_pc_i[IDX_LSB +: SET_W];
  assign lk_tag = lk_pc_i[PC_W-1 -: TAG_W];
  assign up_set = upd_pc_i[IDX_LSB +: SET_W];
  assign up_tag = upd_pc_i[PC_W-1 -: TAG_W];

  hst_way_search u_lk_search (
    .row_i      (rows[lk_set]),
    .tag_i      (lk_tag),
    .hit_o      (lk_hit),
    .hit_way_o  (lk_way),
    .vict_way_o (lk_vict_unused)
  );

  hst_way_search u_up_search (
    .row_i      (rows[up_set]),
    .tag_i      (up_tag),
    .hit_o      (up_hit),
    .hit_way_o  (up_way),
    .vict_way_o (up_vict)
  );

  assign lk_ent    = rows[lk_set][lk_way];
  assign lk_hit_o  = lk_hit;
  assign lk_skip_o = lk_hit ? lk_ent.skip : '0;
  assign lk_cnt_o  = lk_hit ? lk_ent.mc   : '0;

  hst_select u_select (
    .match_i     (lk_match_i),
    .skip_i      (lk_skip_o),
    .sel_valid_o (lk_sel_valid_o),
    .sel_o       (lk_sel_o)
  );

  for (genvar s = 0; s < int'(SET_N); s++) begin : g_set
    hst_entry_t [WAY_N-1:0] row_q;
    logic                   wr_en;

    assign wr_en   = upd_valid_i && (up_set == SET_W'(s));
    assign rows[s] = row_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        row_q <= '0;
      end else if (wr_en) begin
        if (up_hit) begin
          if (upd_miss_i) begin
            if (row_q[up_way].mc != '1)   row_q[up_way].mc   <= row_q[up_way].mc + 1'b1;
            if (row_q[up_way].skip != '1) row_q[up_way].skip <= row_q[up_way].skip + 1'b1;
          end else if (row_q[up_way].mc != '0) begin
            row_q[up_way].mc <= row_q[up_way].mc - 1'b1;
          end
        end else if (upd_miss_i) begin
          row_q[up_vict].vld  <= 1'b1;
          row_q[up_vict].tag  <= up_tag;
          row_q[up_vict].mc   <= MC_W'(1);
          row_q[up_vict].skip <= SKIP_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/hist_skip_table_chk.sv
module hist_skip_table_chk
  import hst_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [PC_W-1:0]   lk_pc_i,
  input logic [TBL_N-1:0]  lk_match_i,
  input logic              lk_hit_o,
  input logic [SKIP_W-1:0] lk_skip_o,
  input logic [MC_W-1:0]   lk_cnt_o,
  input logic              lk_sel_valid_o,
  input logic [TBL_W-1:0]  lk_sel_o,
  input logic              upd_valid_i
);
  a_r3_valid_iff_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_sel_valid_o == (|lk_match_i));

  a_r4_sel_is_matching: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_sel_valid_o |-> lk_match_i[lk_sel_o]);

  a_r2_miss_picks_longest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lk_hit_o && lk_sel_valid_o) |-> ((lk_match_i >> lk_sel_o) == TBL_N'(1)));

  a_r1_miss_fields_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> (lk_skip_o == '0 && lk_cnt_o == '0));

  a_r6_resident_skip_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> lk_skip_o != '0);

  a_r12_idle_lookup_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_valid_i && $stable(lk_pc_i) && $stable(lk_match_i)) |=>
      ($stable(lk_hit_o) && $stable(lk_skip_o) && $stable(lk_cnt_o)));
endmodule

bind hist_skip_table hist_skip_table_chk u_chk (.*);

// File: tb/hist_skip_table_test.sv
module hist_skip_table_test;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] lk_pc_i = '0;
  logic [11:0] lk_match_i = '0;
  logic        lk_hit_o;
  logic [3:0]  lk_skip_o;
  logic [2:0]  lk_cnt_o;
  logic        lk_sel_valid_o;
  logic [3:0]  lk_sel_o;
  logic        upd_valid_i = 1'b0;
  logic [31:0] upd_pc_i = '0;
  logic        upd_miss_i = 1'b0;

  int nvec = 0;
  int nerr = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  hist_skip_table uut (.*);

  function automatic logic [31:0] mk_pc(int set, int tag);
    return {tag[26:0], set[2:0], 2'b00};
  endfunction

  // expected table index: skip x longest matches, fall back to shortest
  function automatic int exp_sel(logic [11:0] m, int x);
    int seen = 0;
    int low = 0;
    int pick = -1;
    for (int i = 11; i >= 0; i--) begin
      if (m[i]) begin
        if (pick < 0 && seen == x) pick = i;
        seen++;
        low = i;
      end
    end
    return (pick < 0) ? low : pick;
  endfunction

  task automatic chk(string req, int act, int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic upd(logic [31:0] pc, logic miss);
    @(negedge clk_i);
    upd_valid_i = 1'b1;
    upd_pc_i    = pc;
    upd_miss_i  = miss;
    @(negedge clk_i);
    upd_valid_i = 1'b0;
  endtask

  task automatic look(string req, logic [31:0] pc, int hit, int skip, int cnt);
    lk_pc_i = pc;
    #1;
    chk({req, " hit"}, int'(lk_hit_o), hit);
    chk({req, " skip"}, int'(lk_skip_o), skip);
    chk({req, " cnt"}, int'(lk_cnt_o), cnt);
  endtask

  task automatic sweep(string req, logic [31:0] pc, int x);
    lk_pc_i = pc;
    for (int m = 0; m < 4096; m++) begin
      lk_match_i = 12'(m);
      #1;
      chk({req, " valid"}, int'(lk_sel_valid_o), (m != 0) ? 1 : 0);
      chk({req, " sel"}, int'(lk_sel_o), (m != 0) ? exp_sel(12'(m), x) : 0);
    end
    lk_match_i = '0;
  endtask

  initial begin
    #(CLK_P * 150000);
    nerr++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [31:0] pa;
    pa = mk_pc(5, 7);
    #(CLK_P * 3);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1
    look("R1 reset", pa, 0, 0, 0);
    look("R1 reset", mk_pc(0, 0), 0, 0, 0);

    // R2 R3 R5 sweep on a miss (skip 0)
    sweep("R2 R3 miss", pa, 0);

    // R12 R6: allocate; not visible before the edge
    @(negedge clk_i);
    lk_pc_i = pa;
    upd_valid_i = 1'b1; upd_pc_i = pa; upd_miss_i = 1'b1;
    #1;
    chk("R12 before edge hit", int'(lk_hit_o), 0);
    @(negedge clk_i);
    upd_valid_i = 1'b0;
    look("R6 alloc", pa, 1, 1, 1);
    sweep("R4 R5 skip1", pa, 1);

    // R7 increments, R4 example
    upd(pa, 1'b1);
    look("R7 inc", pa, 1, 2, 2);
    lk_match_i = 12'b0000_0001_1010;
    #1;
    chk("R4 example sel", int'(lk_sel_o), 1);
    lk_match_i = '0;
    sweep("R4 R5 skip2", pa, 2);
    upd(pa, 1'b1);
    look("R7 inc", pa, 1, 3, 3);
    sweep("R4 R5 skip3", pa, 3);
    upd(pa, 1'b1);
    look("R7 inc", pa, 1, 4, 4);
    sweep("R4 R5 skip4", pa, 4);
    for (int k = 0; k < 16; k++) upd(pa, 1'b1);
    look("R7 saturate", pa, 1, 15, 7);
    sweep("R5 skip15", pa, 15);

    // R8 decrement, skip held
    upd(pa, 1'b0);
    look("R8 dec", pa, 1, 15, 6);
    for (int k = 0; k < 10; k++) upd(pa, 1'b0);
    look("R8 floor", pa, 1, 15, 0);

    // R9
    upd(mk_pc(6, 3), 1'b0);
    look("R9 no alloc", mk_pc(6, 3), 0, 0, 0);

    // R11 same tag different set
    upd(mk_pc(2, 9), 1'b1);
    look("R11 resident", mk_pc(2, 9), 1, 1, 1);
    look("R11 other set", mk_pc(3, 9), 0, 0, 0);

    // R10 R11 victim selection in set 0
    for (int t = 1; t <= 4; t++) upd(mk_pc(0, t), 1'b1);
    for (int t = 1; t <= 4; t++) look("R11 four ways", mk_pc(0, t), 1, 1, 1);
    for (int k = 0; k < 3; k++) upd(mk_pc(0, 1), 1'b1);
    upd(mk_pc(0, 2), 1'b1);
    upd(mk_pc(0, 3), 1'b0);
    upd(mk_pc(0, 5), 1'b1);
    look("R10 evict smallest", mk_pc(0, 3), 0, 0, 0);
    look("R10 new entry", mk_pc(0, 5), 1, 1, 1);
    look("R10 kept", mk_pc(0, 1), 1, 4, 4);
    look("R10 kept", mk_pc(0, 2), 1, 2, 2);
    upd(mk_pc(0, 6), 1'b1);
    look("R10 tie lowest way", mk_pc(0, 5), 0, 0, 0);
    look("R10 tie kept", mk_pc(0, 4), 1, 1, 1);
    look("R10 tie new", mk_pc(0, 6), 1, 1, 1);

    // R10 invalid way beats valid count-0 way (set 1)
    upd(mk_pc(1, 1), 1'b1);
    upd(mk_pc(1, 2), 1'b1);
    upd(mk_pc(1, 1), 1'b0);
    upd(mk_pc(1, 3), 1'b1);
    look("R10 invalid first", mk_pc(1, 1), 1, 1, 0);
    look("R10 invalid first", mk_pc(1, 2), 1, 1, 1);
    look("R10 invalid first", mk_pc(1, 3), 1, 1, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule